// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block is a bit-manipulation engine that uses a one-bit carry flag as its accumulator. It holds a store of individually addressable bits. Each operation names one bit by address and an operation code. The block can set, clear or invert a stored bit or the carry. It can move a value between a bit and the carry. It can fold a bit, or the inverse of that bit, into the carry with AND or OR. It can also evaluate a branch condition on a bit or on the carry.

A controller presents one operation per clock, qualified by a valid strobe. The branch-taken result is raised for exactly one cycle and is left to the surrounding sequencer. One test operation, the set-and-clear test, reports the bit and clears it in the same clock edge. This makes it usable as an atomic flag consume. The current value of the addressed bit is always visible on an output, so the store can be inspected through the normal interface.

The reset input is asynchronous and active-low. Its release is synchronised inside the block.

Top module: `bitproc_unit`

## Requirements
- R1: While reset is asserted and after its release, every stored bit, the carry and branch_taken are 0.
- R2: Opcode 0x00 sets, 0x01 clears and 0x02 inverts the bit at bit_addr, and no other bit changes.
- R3: Opcode 0x03 sets, 0x04 clears and 0x05 inverts the carry, and the bit store is unchanged.
- R4: Opcode 0x06 copies the addressed bit into the carry. Opcode 0x07 copies the carry into the addressed bit.
- R5: Opcode 0x08 gives carry = carry AND bit, 0x09 gives carry AND NOT bit, 0x0A gives carry OR bit, and 0x0B gives carry OR NOT bit.
- R6: Opcode 0x0C (test-not-set) branches when the bit is 0. Opcode 0x0E (test-set) branches when the bit is 1. Neither changes the bit.
- R7: Opcode 0x0D (test-set-and-clear) branches when the bit is 1 and clears that bit on the same edge. When the bit is 0 it neither branches nor changes anything.
- R8: Opcode 0x0F branches when the carry is 1. Opcode 0x10 branches when the carry is 0.
- R9: branch_taken is high only in the single cycle after a valid, true test operation. It is 0 after every other cycle.
- R10: With valid low, or with an opcode from 0x11 to 0x1F, neither the carry, the bit store nor branch_taken changes, and branch_taken stays 0.
- R11: Operations that do not target the carry leave it unchanged. Operations that write no bit leave the whole store unchanged.
- R12: bit_value shows, in the same cycle, the stored value of the bit selected by bit_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| valid | input | 1 | Operation strobe for this cycle |
| op | input | 5 | Operation code |
| bit_addr | input | ADDR_W (8) | Address of the operand bit |
| carry | output | 1 | Current carry flag |
| branch_taken | output | 1 | Test result of the previous cycle's operation |
| bit_value | output | 1 | Current value of the bit at bit_addr |

## Verification
The bench builds the block with its default values: ADDR_W of 8, which gives a 256-bit store, and a two-stage reset synchroniser. With these values it can sweep every address after reset and reach the top address 0xFF as an operand. The random phase aims most operations at a small cluster of addresses. Sets, clears, moves and test-and-clear operations therefore land on the same bits again and again, and so reach combinations such as a test-and-clear on a bit that an earlier operation has just cleared. Invalid strobes and reserved opcodes are mixed into the same stream.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_SETB  = 5'h00,
    OP_CLRB  = 5'h01,
    OP_CPLB  = 5'h02,
    OP_SETC  = 5'h03,
    OP_CLRC  = 5'h04,
    OP_CPLC  = 5'h05,
    OP_MOVCB = 5'h06,
    OP_MOVBC = 5'h07,
    OP_ANLC  = 5'h08,
    OP_ANLCN = 5'h09,
    OP_ORLC  = 5'h0A,
    OP_ORLCN = 5'h0B,
    OP_JNB   = 5'h0C,
    OP_JBC   = 5'h0D,
    OP_JB    = 5'h0E,
    OP_JC    = 5'h0F,
    OP_JNC   = 5'h10
  } op_e;

  localparam logic [OP_W-1:0] OP_LAST = 5'h10;

  typedef struct packed {
    logic carry_we;
    logic carry_d;
    logic bit_we;
    logic bit_d;
    logic branch;
  } exec_t;

endpackage

// File: rtl/bitproc_rst_sync.sv
module bitproc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/bitproc_exec.sv
module bitproc_exec
  import bitproc_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            bit_i,
  input  logic            carry_i,
  output exec_t           res_o
);

  logic operand;

  always_comb begin
    // inverted-operand forms carry a 1 in the low opcode bit
    operand = op_i[0] ? ~bit_i : bit_i;
  end

  always_comb begin
    res_o = '0;
    if (valid_i) begin
      case (op_e'(op_i))
        OP_SETB:  begin res_o.bit_we   = 1'b1; res_o.bit_d   = 1'b1;               end
        OP_CLRB:  begin res_o.bit_we   = 1'b1; res_o.bit_d   = 1'b0;               end
        OP_CPLB:  begin res_o.bit_we   = 1'b1; res_o.bit_d   = ~bit_i;             end
        OP_SETC:  begin res_o.carry_we = 1'b1; res_o.carry_d = 1'b1;               end
        OP_CLRC:  begin res_o.carry_we = 1'b1; res_o.carry_d = 1'b0;               end
        OP_CPLC:  begin res_o.carry_we = 1'b1; res_o.carry_d = ~carry_i;           end
        OP_MOVCB: begin res_o.carry_we = 1'b1; res_o.carry_d = bit_i;              end
        OP_MOVBC: begin res_o.bit_we   = 1'b1; res_o.bit_d   = carry_i;            end
        OP_ANLC,
        OP_ANLCN: begin res_o.carry_we = 1'b1; res_o.carry_d = carry_i & operand;  end
        OP_ORLC,
        OP_ORLCN: begin res_o.carry_we = 1'b1; res_o.carry_d = carry_i | operand;  end
        OP_JNB:   res_o.branch = ~bit_i;
        OP_JB:    res_o.branch = bit_i;
        OP_JBC:   begin
                    res_o.branch = bit_i;
                    res_o.bit_we = bit_i;
                    res_o.bit_d  = 1'b0;
                  end
        OP_JC:    res_o.branch = carry_i;
        OP_JNC:   res_o.branch = ~carry_i;
        default:  res_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/bitproc_bitstore.sv
module bitproc_bitstore #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] bits_q;
  logic [DEPTH-1:0] bit_we;

  always_comb begin
    bit_we = '0;
    if (wr_en) bit_we[wr_addr] = 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bits_q[i] <= 1'b0;
      else if (bit_we[i]) bits_q[i] <= wr_data;
    end
  end

  assign rd_data = bits_q[rd_addr];

  // R2: a write lands in the addressed cell on the next edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bits_q[$past(wr_addr)] == $past(wr_data));

  // R11: without a write the whole store holds
  p_store_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bits_q));

  // a write touches at most one cell
  p_one_cell_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bits_q ^ $past(bits_q)) <= 1);

endmodule

// File: rtl/bitproc_unit.sv
module bitproc_unit
  import bitproc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [4:0]        op,
  input  logic [ADDR_W-1:0] bit_addr,
  output logic              carry,
  output logic              branch_taken,
  output logic              bit_value
);

  logic  rst_sync_n;
  logic  bit_rd;
  exec_t res;
  logic  carry_q, carry_d;
  logic  branch_q, branch_d;

  bitproc_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  bitproc_bitstore #(
    .ADDR_W (ADDR_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (res.bit_we),
    .wr_addr (bit_addr),
    .wr_data (res.bit_d),
    .rd_addr (bit_addr),
    .rd_data (bit_rd)
  );

  bitproc_exec u_exec (
    .valid_i (valid),
    .op_i    (op),
    .bit_i   (bit_rd),
    .carry_i (carry_q),
    .res_o   (res)
  );

  always_comb begin
    carry_d  = res.carry_we ? res.carry_d : carry_q;
    branch_d = res.branch;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      carry_q  <= 1'b0;
      branch_q <= 1'b0;
    end else begin
      carry_q  <= carry_d;
      branch_q <= branch_d;
    end
  end

  assign carry        = carry_q;
  assign branch_taken = branch_q;
  assign bit_value    = bit_rd;

  // R9: a branch only follows a strobed cycle
  p_branch_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    branch_taken |-> $past(valid));

  // R9: an idle cycle never yields a branch
  p_idle_no_branch_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !valid |=> !branch_taken);

  // R6: test-not-set on a clear bit branches
  p_jnb_taken_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid && op == OP_JNB && !bit_value) |=> branch_taken);

  // R7: test-and-clear on a set bit branches
  p_jbc_taken_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid && op == OP_JBC && bit_value) |=> branch_taken);

  // R3: set-carry forces carry high
  p_setc_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid && op == OP_SETC) |=> carry);

  // R4: move bit to carry
  p_movcb_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid && op == OP_MOVCB) |=> carry == $past(bit_value));

  // R11: bit-only operations hold the carry
  p_carry_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!valid || op == OP_SETB || op == OP_CLRB || op == OP_CPLB || op == OP_MOVBC
     || op == OP_JNB || op == OP_JBC || op == OP_JB) |=> $stable(carry));

  // R10: reserved opcodes do nothing
  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid && op > OP_LAST) |=> ($stable(carry) && !branch_taken));

endmodule

// File: tb/bitproc_unit_bench.sv
module bitproc_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       valid;
  logic [4:0] op;
  logic [7:0] bit_addr;
  wire        carry;
  wire        branch_taken;
  wire        bit_value;

  int checks   = 0;
  int failures = 0;
  bit chk_en   = 1'b0;

  // reference state
  bit         m_mem [256];
  bit         m_carry;
  bit         m_branch;
  logic [4:0] m_last_op;
  bit         m_last_valid;

  always #4 clk = ~clk;

  bitproc_unit u_bitproc_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid        (valid),
    .op           (op),
    .bit_addr     (bit_addr),
    .carry        (carry),
    .branch_taken (branch_taken),
    .bit_value    (bit_value)
  );

  function automatic string tag_of(bit v, logic [4:0] o);
    if (!v)        return "R10";
    if (o <= 5'h02) return "R2";
    if (o <= 5'h05) return "R3";
    if (o <= 5'h07) return "R4";
    if (o <= 5'h0B) return "R5";
    if (o == 5'h0D) return "R7";
    if (o <= 5'h0E) return "R6";
    if (o <= 5'h10) return "R8";
    return "R10";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_mem[i] = 1'b0;
      m_carry = 1'b0; m_branch = 1'b0;
      m_last_op = 5'h1F; m_last_valid = 1'b0;
    end else begin
      bit b;
      b = m_mem[bit_addr];
      m_branch = 1'b0;
      m_last_op = op; m_last_valid = valid;
      if (valid) begin
        case (op)
          5'h00: m_mem[bit_addr] = 1'b1;
          5'h01: m_mem[bit_addr] = 1'b0;
          5'h02: m_mem[bit_addr] = !b;
          5'h03: m_carry = 1'b1;
          5'h04: m_carry = 1'b0;
          5'h05: m_carry = !m_carry;
          5'h06: m_carry = b;
          5'h07: m_mem[bit_addr] = m_carry;
          5'h08: m_carry = m_carry && b;
          5'h09: m_carry = m_carry && !b;
          5'h0A: m_carry = m_carry || b;
          5'h0B: m_carry = m_carry || !b;
          5'h0C: m_branch = !b;
          5'h0D: begin m_branch = b; if (b) m_mem[bit_addr] = 1'b0; end
          5'h0E: m_branch = b;
          5'h0F: m_branch = m_carry;
          5'h10: m_branch = !m_carry;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string t;
    t = tag_of(m_last_valid, m_last_op);
    chk(carry, m_carry, t, "carry");
    chk(branch_taken, m_branch, m_branch ? t : "R9", "branch_taken");
    chk(bit_value, m_mem[bit_addr], "R12", "bit_value");
  endtask

  task automatic step(input bit v, input logic [4:0] o, input logic [7:0] a);
    @(negedge clk);
    if (chk_en) compare_all();
    valid = v; op = o; bit_addr = a;
  endtask

  task automatic after(input logic ec, input logic eb, input logic ebit, input string tag);
    @(negedge clk);
    compare_all();
    chk(carry, ec, tag, "carry (directed)");
    chk(branch_taken, eb, tag, "branch (directed)");
    chk(bit_value, ebit, tag, "bit (directed)");
    valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; op = 5'h00; bit_addr = 8'h00;
    repeat (5) @(negedge clk);
    // R1: reset values while reset is held
    chk(carry, 1'b0, "R1", "carry in reset");
    chk(branch_taken, 1'b0, "R1", "branch in reset");
    chk(bit_value, 1'b0, "R1", "bit in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_en = 1'b1;
    // R1 and R12: every address reads 0 after reset
    for (int a = 0; a < 256; a++) begin
      step(1'b0, 5'h00, 8'(a));
      #1 chk(bit_value, 1'b0, "R1", "swept bit");
    end

    step(1'b1, 5'h00, 8'h40); after(1'b0, 1'b0, 1'b1, "R2");
    step(1'b1, 5'h0E, 8'h40); after(1'b0, 1'b1, 1'b1, "R6");
    step(1'b1, 5'h0D, 8'h40); after(1'b0, 1'b1, 1'b0, "R7");
    step(1'b1, 5'h0D, 8'h40); after(1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, 5'h0C, 8'h40); after(1'b0, 1'b1, 1'b0, "R6");
    step(1'b1, 5'h03, 8'h40); after(1'b1, 1'b0, 1'b0, "R3");
    step(1'b1, 5'h07, 8'hFF); after(1'b1, 1'b0, 1'b1, "R4");
    step(1'b1, 5'h0F, 8'hFF); after(1'b1, 1'b1, 1'b1, "R8");
    step(1'b1, 5'h09, 8'hFF); after(1'b0, 1'b0, 1'b1, "R5");
    step(1'b1, 5'h10, 8'hFF); after(1'b0, 1'b1, 1'b1, "R8");
    step(1'b1, 5'h0B, 8'h40); after(1'b1, 1'b0, 1'b0, "R5");
    step(1'b1, 5'h1F, 8'hFF); after(1'b1, 1'b0, 1'b1, "R10");
    step(1'b0, 5'h01, 8'hFF); after(1'b1, 1'b0, 1'b1, "R10");
    step(1'b1, 5'h02, 8'h41); after(1'b1, 1'b0, 1'b1, "R11");
    step(1'b1, 5'h06, 8'h40); after(1'b0, 1'b0, 1'b0, "R4");

    // random mix concentrated on a few addresses
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      a = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 5));
      step($urandom_range(0, 9) != 0, 5'($urandom_range(0, 19)), a);
    end
    step(1'b0, 5'h00, 8'h00);
    step(1'b0, 5'h00, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule